// File: doc/BRIEF.md
# Table-Driven Double-Error BCH Block Decoder

This block decodes 31-bit blocks of a binary BCH code that carries 21 data bits and corrects up to two bit errors. A new block enters on every clock. The block is registered on entry, and a remainder of 10 bits is formed from it by fixed XOR trees. That remainder indexes a pattern table that is filled while the design elaborates. The table holds one entry for every error pattern of weight one or two, which is 31 + 465 = 496 entries out of 1024 slots. The selected pattern is XORed into the stored block, and the result leaves through an output register.

A zero remainder means the block is already a code word, and it passes unchanged. A nonzero remainder that points at an empty slot cannot come from two or fewer errors. In that case the block is forwarded unchanged and a flag is raised. No control state exists beyond the three register stages, so every output depends only on the input three edges earlier.

Top module: `bch_lut_decoder`

## Requirements
- R1: While the active-low reset is held, the decoded block output and the uncorrectable flag both read zero.
- R2: A block presented before rising edge E appears at the outputs after edge E+2. The decoder accepts a new block on every cycle with no gaps.
- R3: The bit layout is fixed. Bit j is the coefficient of x^j. Data sits in bits 30..10 and check bits in bits 9..0. A valid word is a multiple of g(x) = x^10+x^9+x^8+x^6+x^5+x^3+1 (0x769).
- R4: A valid code word is output unchanged, with the flag clear.
- R5: A code word with any one bit flipped, at any of the 31 positions, is restored, with the flag clear.
- R6: A code word with any two distinct bits flipped, for all 465 pairs, is restored, with the flag clear.
- R7: If the remainder is nonzero and no stored pattern matches it, the received block is output unchanged and the flag is set.
- R8: A block with three or more errors gives one of two results. Either it is passed through with the flag set, or it is output as a valid word within distance two of the received block, with the flag clear.
- R9: Any pattern applied to a block has weight at most two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_block | input | 31 | Received block, bit j = coefficient of x^j |
| dec_block | output | 31 | Corrected (or forwarded) block |
| dec_uncorr | output | 1 | Set when no weight-two-or-less pattern explains the remainder |

## Verification
Clean code words built from several data values establish the zero-remainder pass-through. A sweep over every single-bit and every two-bit error on each of those words covers all 496 table entries, which separates a wrong slot, a wrong column of the check matrix or a missing entry from a correct table. Fixed three-bit error patterns reach both the empty-slot path and the miscorrection path, and tell the flag logic apart from the correction XOR. Back-to-back streaming of single-error blocks separates a true three-stage pipeline from one that drops or repeats a block.

// File: rtl/bch_lut_pkg.sv
package bch_lut_pkg;

    localparam int          BCH_N     = 31;
    localparam int          BCH_M     = 10;
    localparam logic [31:0] BCH_GPOLY = 32'h0000_0769;

    // x^j mod g(x), as an m-bit remainder held in a 32-bit word
    function automatic logic [31:0] poly_col(input int j, input int m,
                                             input logic [31:0] gpoly);
        logic [31:0] c;
        c = 32'd1;
        for (int k = 0; k < j; k++) begin
            c = c << 1;
            if (c[m]) c = c ^ gpoly;
        end
        return c;
    endfunction

endpackage

// File: rtl/bch_syndrome.sv
module bch_syndrome
    import bch_lut_pkg::*;
#(
    parameter int          N     = BCH_N,
    parameter int          M     = BCH_M,
    parameter logic [31:0] GPOLY = BCH_GPOLY
) (
    input  logic [N-1:0] blk,
    output logic [M-1:0] syn
);

    // Row s of the check matrix: which block bits feed remainder bit s
    function automatic logic [N-1:0] row_mask(input int s);
        logic [N-1:0] msk;
        logic [31:0]  c;
        msk = '0;
        for (int j = 0; j < N; j++) begin
            c      = poly_col(j, M, GPOLY);
            msk[j] = c[s];
        end
        return msk;
    endfunction

    for (genvar s = 0; s < M; s++) begin : g_row
        localparam logic [N-1:0] MASK = row_mask(s);
        assign syn[s] = ^(blk & MASK);
    end

endmodule

// File: rtl/bch_pattern_lut.sv
module bch_pattern_lut
    import bch_lut_pkg::*;
#(
    parameter int          N     = BCH_N,
    parameter int          M     = BCH_M,
    parameter logic [31:0] GPOLY = BCH_GPOLY
) (
    input  logic [M-1:0] syn,
    output logic [N-1:0] pat
);

    localparam int DEPTH = 1 << M;

    typedef logic [DEPTH-1:0][N-1:0] tbl_t;

    // Fill every slot reachable by an error of weight one or two
    function automatic tbl_t build_table();
        tbl_t        t;
        logic [M-1:0] cols [N];
        logic [31:0]  c;
        t = '0;
        for (int j = 0; j < N; j++) begin
            c       = poly_col(j, M, GPOLY);
            cols[j] = c[M-1:0];
            t[cols[j]]    = '0;
            t[cols[j]][j] = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                t[cols[i] ^ cols[j]]    = '0;
                t[cols[i] ^ cols[j]][i] = 1'b1;
                t[cols[i] ^ cols[j]][j] = 1'b1;
            end
        end
        return t;
    endfunction

    localparam tbl_t TABLE = build_table();

    assign pat = TABLE[syn];

endmodule

// File: rtl/bch_lut_decoder.sv
module bch_lut_decoder
    import bch_lut_pkg::*;
#(
    parameter int          N     = BCH_N,
    parameter int          M     = BCH_M,
    parameter logic [31:0] GPOLY = BCH_GPOLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rx_block,
    output logic [N-1:0] dec_block,
    output logic         dec_uncorr
);

    logic [N-1:0] rx_q;
    logic [M-1:0] syn_d;
    logic [M-1:0] syn_q;
    logic [N-1:0] blk_q;
    logic [N-1:0] lut_pat;
    logic [N-1:0] fix_d;
    logic         unc_d;

    bch_syndrome #(.N(N), .M(M), .GPOLY(GPOLY)) u_syn (
        .blk (rx_q),
        .syn (syn_d)
    );

    bch_pattern_lut #(.N(N), .M(M), .GPOLY(GPOLY)) u_lut (
        .syn (syn_q),
        .pat (lut_pat)
    );

    // Stage 0 and stage 1: input register, then remainder + block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            syn_q <= '0;
            blk_q <= '0;
        end else begin
            rx_q  <= rx_block;
            syn_q <= syn_d;
            blk_q <= rx_q;
        end
    end

    // Correction and miss detection ahead of the output register
    always_comb begin
        unc_d = (syn_q != '0) && (lut_pat == '0);
        fix_d = blk_q ^ lut_pat;
    end

    // Stage 2: output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_block  <= '0;
            dec_uncorr <= 1'b0;
        end else begin
            dec_block  <= fix_d;
            dec_uncorr <= unc_d;
        end
    end

endmodule

// File: rtl/bch_lut_decoder_chk.sv
module bch_lut_decoder_chk #(
    parameter int N = 31,
    parameter int M = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] rx_block,
    input logic [N-1:0] dec_block,
    input logic         dec_uncorr,
    input logic [M-1:0] syn_q,
    input logic [N-1:0] blk_q,
    input logic [N-1:0] lut_pat
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (armed && !rst_n) |-> (dec_block == '0 && !dec_uncorr));

    // R4
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_q == '0) |=> (dec_block == $past(blk_q) && !dec_uncorr));

    // R7
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_q != '0 && lut_pat == '0) |=> (dec_uncorr && dec_block == $past(blk_q)));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_uncorr |-> (dec_block == $past(rx_block, 3)));

    // R9
    weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lut_pat) <= 2);

    // R5
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_pat != '0) |=> !dec_uncorr);

endmodule

bind bch_lut_decoder bch_lut_decoder_chk #(.N(N), .M(M)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_block   (rx_block),
    .dec_block  (dec_block),
    .dec_uncorr (dec_uncorr),
    .syn_q      (syn_q),
    .blk_q      (blk_q),
    .lut_pat    (lut_pat)
);

// File: tb/bch_lut_decoder_bench.sv
`timescale 1ns/1ps
module bch_lut_decoder_bench;

    localparam int NB = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] rx_blk = '0;
    logic [NB-1:0] dec_blk;
    logic          dec_unc;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    bch_lut_decoder u_bch_lut_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_block   (rx_blk),
        .dec_block  (dec_blk),
        .dec_uncorr (dec_unc)
    );

    // remainder of v(x) divided by 0x769 (R3)
    function automatic logic [9:0] rem_of(input logic [NB-1:0] v);
        logic [NB-1:0] r;
        r = v;
        for (int i = NB - 1; i >= 10; i--)
            if (r[i]) r = r ^ (31'h769 << (i - 10));
        return r[9:0];
    endfunction

    function automatic logic [NB-1:0] encode(input logic [20:0] msg);
        return {msg, rem_of({msg, 10'b0})};
    endfunction

    task automatic check(input string req, input logic [NB-1:0] got,
                         input logic [NB-1:0] exp, input logic gotf,
                         input logic expf);
        checks++;
        if (got !== exp || gotf !== expf) begin
            errors++;
            $display("FAIL %s: block %h flag %b, expected block %h flag %b",
                     req, got, gotf, exp, expf);
        end
    endtask

    task automatic run_one(input string req, input logic [NB-1:0] blk,
                           input logic [NB-1:0] exp, input logic expf);
        @(negedge clk) rx_blk = blk;
        repeat (3) @(negedge clk);
        check(req, dec_blk, exp, dec_unc, expf);
    endtask

    logic [20:0] msgs [4] = '{21'h000000, 21'h1FFFFF, 21'h0A5A5A, 21'h15A3C7};

    initial begin
        logic [NB-1:0] cw;
        logic [NB-1:0] rb;
        logic [NB-1:0] sexp [NB];
        int            flagged;
        bit            ok;

        // R1: reset state with a live input
        rx_blk = 31'h5555_1234;
        repeat (3) @(negedge clk);
        check("R1", dec_blk, '0, dec_unc, 1'b0);
        rst_n = 1'b1;

        // R3: encoder sanity on a hand value, remainder of x^10 mod g
        checks++;
        if (rem_of(31'h400) !== 10'h369) begin
            errors++;
            $display("FAIL R3: remainder %h expected %h", rem_of(31'h400), 10'h369);
        end

        foreach (msgs[m]) begin
            cw = encode(msgs[m]);
            run_one("R4", cw, cw, 1'b0);
            for (int i = 0; i < NB; i++) begin
                rb = cw; rb[i] = ~rb[i];
                run_one("R5", rb, cw, 1'b0);
            end
            for (int i = 0; i < NB; i++) begin
                for (int j = i + 1; j < NB; j++) begin
                    rb = cw; rb[i] = ~rb[i]; rb[j] = ~rb[j];
                    run_one("R6", rb, cw, 1'b0);
                end
            end
        end

        // R8 / R7: three-bit errors
        flagged = 0;
        cw = encode(msgs[3]);
        for (int i = 0; i < NB; i++) begin
            for (int v = 0; v < 2; v++) begin
                rb = cw;
                rb[i] = ~rb[i];
                rb[(i + 1 + 4 * v) % NB] = ~rb[(i + 1 + 4 * v) % NB];
                rb[(i + 3 + 8 * v) % NB] = ~rb[(i + 3 + 8 * v) % NB];
                @(negedge clk) rx_blk = rb;
                repeat (3) @(negedge clk);
                ok = (dec_unc && dec_blk == rb) ||
                     (!dec_unc && rem_of(dec_blk) == 10'h0 &&
                      $countones(dec_blk ^ rb) <= 2);
                if (dec_unc) flagged++;
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL R8: block %h flag %b for received %h",
                             dec_blk, dec_unc, rb);
                end
            end
        end
        checks++;
        if (flagged == 0) begin
            errors++;
            $display("FAIL R7: flagged count %0d, expected above 0", flagged);
        end

        // R2: back-to-back stream of single-error blocks
        cw = encode(msgs[2]);
        for (int i = 0; i < NB + 3; i++) begin
            @(negedge clk);
            if (i >= 3) check("R2", dec_blk, sexp[i - 3], dec_unc, 1'b0);
            if (i < NB) begin
                rb = cw; rb[i] = ~rb[i];
                sexp[i] = cw;
                rx_blk = rb;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2: watchdog, run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule